// File: doc/BRIEF.md
# SMBus Slave Interface with Clock-Low Timeout

This block is the bus-facing half of a small SMBus/I2C peripheral. It samples the clock and data lines with its own core clock. It recognises START, repeated START and STOP conditions, and it answers at one of four 7-bit addresses. The upper five bits of that address are a build parameter. Two strap inputs supply the lowest two bits, so four copies of the same device can share one bus.

In a write, the first data byte sets a register pointer. Each later byte produces a one-cycle write strobe toward an attached register file, and the pointer then advances. In a read, the byte addressed by the pointer is fetched from the register file and shifted out. The usual form is a pointer write, then a repeated START, then a read. Each byte the master acknowledges advances the pointer.

A watchdog counts core cycles while SCK is low during a transaction. If the line stays low for the configured window (about 30 ms at the nominal 4 MHz core clock), the slave drops SDA and returns to idle. A bus master that stalls therefore cannot leave the slave holding the data line low.

Top module: `smb_slave_tmo`

## Requirements
- R1: After reset, SDA is released (`sda_low`=0), both strobes are low and `reg_ptr` is 0.
- R2: An address byte (bits 7:1 address, bit 0 = 1 for read, sent MSB first) whose address equals {ADDR_HI, strap} is acknowledged by driving SDA low through the ninth clock.
- R3: After an address that does not match, SDA is never driven and no strobe fires until the next START, even if later bytes look like a matching address.
- R4: The first data byte of a write transaction loads `reg_ptr`, is acknowledged, and produces no write strobe.
- R5: Each further write byte is acknowledged and gives a one-cycle `wr_stb` with the byte on `wr_data` and the target on `reg_ptr`. After that byte's ACK clock, `reg_ptr` advances by one, wrapping at 2^PTR_W.
- R6: A read shifts out `rd_data` at `reg_ptr`, MSB first, with a one-cycle `rd_stb`. A master ACK (SDA low on the ninth clock) advances the pointer and starts the next byte. A NACK leaves the pointer unchanged and the slave stays off the bus until the next START.
- R7: A repeated START without a STOP is accepted, and the pointer set by the preceding write is kept for the read that follows.
- R8: A START arriving in the middle of a byte discards the partial byte without a strobe and restarts address reception.
- R9: After a STOP, clocked bits are ignored until the next START. No ACK is given and the pointer is unchanged.
- R10: If SCK stays low for TMO_CYC core cycles during a transaction, SDA is released and the slave returns to idle, ignoring bits until the next START. Low periods shorter than TMO_CYC leave the transaction intact.
- R11: Changing `strap` selects which of the four addresses {ADDR_HI, 00..11} the slave answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap | input | 2 | Address-select straps, become address bits 1:0 |
| sda_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_ptr | output | PTR_W | Register pointer toward the register file |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Byte written, valid with `wr_stb` |
| rd_stb | output | 1 | One-cycle pulse when a read byte has been taken |
| rd_data | input | 8 | Register file contents at `reg_ptr` |

## Verification
Two actions share one SCK falling edge in a write. The slave starts driving the ACK and raises the write strobe on that edge, while the pointer must still show the byte's target. The pointer step comes only on the next falling edge. The bench checks the strobed byte and its target against its own register-file model after every data byte, and checks the pointer only after the ACK clock. A wrong ordering would land data one register off, and the read-back loop would catch it. The timeout is tested from both sides: pauses well below the window must leave a write intact, and a pause well beyond it while the slave holds ACK must release SDA.

// File: rtl/smb_slave_tmo.sv
`timescale 1ns/1ps
module smb_slave_tmo #(
  parameter logic [4:0] ADDR_HI = 5'b10110,
  parameter int         TMO_CYC = 120000,
  parameter int         PTR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       strap,
  output logic             sda_low,
  output logic [PTR_W-1:0] reg_ptr,
  output logic             wr_stb,
  output logic [7:0]       wr_data,
  output logic             rd_stb,
  input  logic [7:0]       rd_data
);

  localparam int TW = $clog2(TMO_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK, S_SKIP} st_t;
  st_t st;

  logic [2:0] scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_s   = scl_q[1];
  wire scl_p   = scl_q[2];
  wire sda_s   = sda_q[1];
  wire sda_p   = sda_q[2];
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise    = scl_s & ~scl_p;
  wire fall    = ~scl_s & scl_p;

  logic [3:0]    bcnt;
  logic [7:0]    sh;
  logic          rw, first, wrote, nack;
  logic [TW-1:0] tmo;

  wire tmo_hit = (st != S_IDLE) && !scl_s && (tmo == TW'(TMO_CYC - 1));
  wire adr_ok  = sh[7:1] == {ADDR_HI, strap};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    tmo <= '0;
    else if (st == S_IDLE || scl_s) tmo <= '0;
    else if (!tmo_hit)             tmo <= tmo + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      sda_low <= 1'b0;
      reg_ptr <= '0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
      rd_stb  <= 1'b0;
      bcnt    <= '0;
      sh      <= '0;
      rw      <= 1'b0;
      first   <= 1'b0;
      wrote   <= 1'b0;
      nack    <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (tmo_hit) begin
        st      <= S_IDLE;
        sda_low <= 1'b0;
      end else if (start_c) begin
        st      <= S_ADDR;
        bcnt    <= '0;
        first   <= 1'b1;
        sda_low <= 1'b0;
      end else if (stop_c) begin
        st      <= S_IDLE;
        sda_low <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR:
            if (rise) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 1'b1;
            end else if (fall && bcnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (adr_ok) begin
                  st      <= S_AACK;
                  rw      <= sh[0];
                  sda_low <= 1'b1;
                end else
                  st <= S_SKIP;
              end else begin
                st      <= S_WACK;
                sda_low <= 1'b1;
                wrote   <= !first;
                first   <= 1'b0;
                if (first) reg_ptr <= PTR_W'(sh);
                else begin
                  wr_stb  <= 1'b1;
                  wr_data <= sh;
                end
              end
            end
          S_AACK:
            if (fall) begin
              bcnt <= '0;
              if (rw) begin
                sh      <= rd_data;
                sda_low <= ~rd_data[7];
                rd_stb  <= 1'b1;
                st      <= S_RD;
              end else begin
                sda_low <= 1'b0;
                st      <= S_WR;
              end
            end
          S_WACK:
            if (fall) begin
              sda_low <= 1'b0;
              bcnt    <= '0;
              st      <= S_WR;
              if (wrote) reg_ptr <= reg_ptr + 1'b1;
            end
          S_RD:
            if (rise) bcnt <= bcnt + 1'b1;
            else if (fall) begin
              if (bcnt == 4'd8) begin
                sda_low <= 1'b0;
                st      <= S_RACK;
              end else begin
                sh      <= {sh[6:0], 1'b0};
                sda_low <= ~sh[6];
              end
            end
          S_RACK:
            if (rise) begin
              nack <= sda_s;
              if (!sda_s) reg_ptr <= reg_ptr + 1'b1;
            end else if (fall) begin
              bcnt <= '0;
              if (nack) st <= S_SKIP;
              else begin
                sh      <= rd_data;
                sda_low <= ~rd_data[7];
                rd_stb  <= 1'b1;
                st      <= S_RD;
              end
            end
          default: sda_low <= 1'b0;
        endcase
      end
    end

  a_r5_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb);
  a_r6_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |=> !rd_stb);
  a_r5_ptr_hold:     assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> $stable(reg_ptr));
  a_r3_skip_quiet:   assert property (@(posedge clk) disable iff (!rst_n) (st == S_SKIP) |-> !sda_low && !wr_stb);
  a_r2_drive_engaged: assert property (@(posedge clk) disable iff (!rst_n)
                        sda_low |-> (st == S_AACK || st == S_WACK || st == S_RD));
  a_r10_tmo_release: assert property (@(posedge clk) disable iff (!rst_n)
                        tmo_hit |=> (st == S_IDLE && !sda_low));
  a_r8_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
                        start_c |=> (st == S_ADDR && bcnt == 4'd0));
  a_r9_stop_idle:    assert property (@(posedge clk) disable iff (!rst_n) stop_c |=> st == S_IDLE);

endmodule

// File: tb/smb_slave_tmo_test.sv
`timescale 1ns/1ps
module smb_slave_tmo_test;
  localparam int TMO = 300;
  localparam int Q = 10;
  localparam int H = 20;
  localparam logic [4:0] AHI = 5'b10110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sda_low, wr_stb, rd_stb;
  logic [7:0] reg_ptr, wr_data, rd_data;
  logic [7:0] mem [256];
  wire sda_bus = m_sda & ~sda_low;

  always #2 clk = ~clk;

  smb_slave_tmo #(.ADDR_HI(AHI), .TMO_CYC(TMO), .PTR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap(strap),
    .sda_low(sda_low), .reg_ptr(reg_ptr), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data));

  assign rd_data = mem[reg_ptr];

  int wr_cnt = 0, rd_cnt = 0, low_cnt = 0;
  logic [7:0] last_wd = 8'h00, last_wp = 8'h00;
  always @(posedge clk) begin
    if (wr_stb) begin
      mem[reg_ptr] <= wr_data;
      wr_cnt  <= wr_cnt + 1;
      last_wd <= wr_data;
      last_wp <= reg_ptr;
    end
    if (rd_stb) rd_cnt <= rd_cnt + 1;
    if (sda_low) low_cnt <= low_cnt + 1;
  end

  int checks = 0, errors = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(H/2);
    ack = ~sda_bus; tick(H/2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(H/2);
      b[i] = sda_bus; tick(H/2);
      m_scl = 1'b0; tick(Q);
    end
    bit_out(~ack);
    m_sda = 1'b1;
  endtask

  // strap, address, pointer, first byte, second byte
  localparam logic [32:0] VEC [8] = '{
    {2'd0, 7'h58, 8'h10, 8'h3C, 8'hC3},
    {2'd1, 7'h59, 8'h20, 8'h00, 8'hFF},
    {2'd2, 7'h5A, 8'hFE, 8'h81, 8'h7E},
    {2'd3, 7'h5B, 8'hFF, 8'h55, 8'hAA},
    {2'd1, 7'h5A, 8'h30, 8'h11, 8'h22},
    {2'd0, 7'h18, 8'h40, 8'h33, 8'h44},
    {2'd3, 7'h58, 8'h50, 8'h5A, 8'hB1},
    {2'd2, 7'h5A, 8'h60, 8'h01, 8'h80}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b0, b1;
    int wc, rc, lc;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h96;
    tick(5);
    chk("R1 sda released in reset", sda_low, 0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 sda released", sda_low, 0);
    chk("R1 wr_stb low", wr_stb, 0);
    chk("R1 rd_stb low", rd_stb, 0);
    chk("R1 pointer zero", reg_ptr, 0);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] s; logic [6:0] a; logic [7:0] p, d0, d1, o0, o1; logic m;
      {s, a, p, d0, d1} = VEC[v];
      m = (a == {AHI, s});
      strap = s;
      o0 = mem[p]; o1 = mem[8'(p + 1)];
      wc = wr_cnt; lc = low_cnt;
      tick(4);
      bus_start;
      send_byte({a, 1'b0}, ack);  chk("R2 R3 R11 write address ack", ack, m);
      send_byte(p, ack);          chk("R4 pointer byte ack", ack, m);
      if (m) chk("R4 pointer loaded, no strobe", {reg_ptr, 8'(wr_cnt - wc)}, {p, 8'h00});
      send_byte(d0, ack);         chk("R5 data ack", ack, m);
      if (m) chk("R5 strobe target and data", {last_wp, last_wd, 8'(wr_cnt - wc)}, {p, d0, 8'h01});
      send_byte(d1, ack);
      bus_stop;
      if (m) begin
        chk("R5 second strobe", {last_wp, last_wd}, {8'(p + 1), d1});
        chk("R5 pointer advanced twice", reg_ptr, 8'(p + 2));
      end else begin
        chk("R3 no strobes", wr_cnt - wc, 0);
        chk("R3 SDA never driven", low_cnt - lc, 0);
        chk("R3 register untouched", {mem[p], mem[8'(p + 1)]}, {o0, o1});
      end
      rc = rd_cnt;
      bus_start;
      send_byte({a, 1'b0}, ack);
      send_byte(p, ack);
      bus_start;
      send_byte({a, 1'b1}, ack);  chk("R7 read address ack after repeated start", ack, m);
      recv_byte(1'b1, b0);
      recv_byte(1'b0, b1);
      bus_stop;
      if (m) begin
        chk("R6 R7 read bytes", {b0, b1}, {d0, d1});
        chk("R6 pointer after ACK then NACK", reg_ptr, 8'(p + 1));
        chk("R6 read strobes", rd_cnt - rc, 2);
      end else
        chk("R3 read bytes float high", {b0, b1}, 16'hFFFF);
    end

    strap = 2'd0;
    wc = wr_cnt;
    bus_start;
    send_byte(8'hB0, ack);
    send_byte(8'h40, ack);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    bus_start;
    chk("R8 partial byte dropped", wr_cnt - wc, 0);
    send_byte(8'hB0, ack);       chk("R8 address after mid-byte start", ack, 1);
    send_byte(8'h77, ack);
    chk("R8 first byte after restart is pointer", {reg_ptr, 8'(wr_cnt - wc)}, {8'h77, 8'h00});
    bus_stop;

    bus_start;
    send_byte(8'hB0, ack);
    send_byte(8'h10, ack);
    bus_stop;
    send_byte(8'hB0, ack);       chk("R9 no ack after stop", ack, 0);
    send_byte(8'h33, ack);
    chk("R9 pointer unchanged", reg_ptr, 8'h10);

    bus_start;
    for (int i = 7; i >= 0; i--) bit_out(i[0] == 1'b0 && i >= 4 ? ((8'hB0 >> i) & 1) == 1 : ((8'hB0 >> i) & 1) == 1);
    m_sda = 1'b1; tick(Q);
    chk("R2 ack driven during stall", sda_low, 1);
    tick(2 * TMO);
    chk("R10 SDA released after timeout", sda_low, 0);
    m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q);
    send_byte(8'h21, ack);       chk("R10 ignored after timeout", ack, 0);
    chk("R10 pointer unchanged", reg_ptr, 8'h10);
    bus_stop;

    wc = wr_cnt;
    bus_start;
    send_byte(8'hB0, ack);
    tick(TMO * 2 / 3);
    send_byte(8'h05, ack);
    tick(TMO * 2 / 3);
    send_byte(8'hE7, ack);       chk("R10 short stall keeps transaction", ack, 1);
    bus_stop;
    chk("R10 write after short stalls", {last_wp, last_wd, 8'(wr_cnt - wc)}, {8'h05, 8'hE7, 8'h01});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule